// File: doc/BRIEF.md
# Register Bus Window Decoder

This block joins several subordinate register buses behind one upstream register bus. Each subordinate has its own fixed local address width and owns a window of two to the power of that width addresses. The windows are laid out in port order. Each window starts at the first address that follows the previous window and that is also a multiple of the window's own size. The allocation is fixed by parameters when the block is built.

The upstream side presents an address, a read strobe, a write strobe and write data. The window that owns the address gets the strobes and the low address bits. All other windows see no strobe. Write data goes to every subordinate, but only the strobed one acts on it. Each subordinate returns its read data one cycle after its read strobe. The decoder registers which window took each read. It uses that registered copy to pick the returned data and forces the data of every other window to zero. Reads can therefore be issued back to back across windows and still return in order.

Top module: `csr_win_decoder`

## Requirements
- R1: With the default local address widths (10, 10 and 8 bits for subordinates 0, 1 and 2), window 0 covers 0x000-0x3FF, window 1 covers 0x400-0x7FF and window 2 covers 0x800-0x8FF. Upstream addresses are 16 bits wide.
- R2: The address slice for subordinate i is bits [16*i+15:16*i] of `sub_addr`. When window i is strobed, its slice carries the upstream address masked to the window's local width (for example, 0x402 becomes local address 0x002 on subordinate 1).
- R3: A write strobe reaches only the subordinate whose window holds the address, in the same cycle. `sub_wdata` equals `up_wdata`.
- R4: A read strobe reaches only the subordinate whose window holds the address, in the same cycle.
- R5: No more than one bit of `sub_rd` and no more than one bit of `sub_wr` is ever high.
- R6: In the cycle after an upstream read strobe, `up_rdata` equals the data that the selected subordinate presents on its slice of `sub_rdata` (bits [8*i+7:8*i]). The data of every other subordinate is ignored.
- R7: Reads issued on consecutive cycles to different windows return their data on consecutive cycles, in issue order.
- R8: An address outside every window produces no strobe, and the following cycle returns zero read data.
- R9: `up_rdata` is zero after reset and in every cycle that does not follow an upstream read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_addr | input | 16 | Upstream global address |
| up_rd | input | 1 | Upstream read strobe |
| up_wr | input | 1 | Upstream write strobe |
| up_wdata | input | 8 | Upstream write data |
| up_rdata | output | 8 | Returned read data |
| sub_addr | output | 48 | Local address per subordinate, 16 bits each |
| sub_rd | output | 3 | Read strobe per subordinate |
| sub_wr | output | 3 | Write strobe per subordinate |
| sub_wdata | output | 8 | Write data shared by all subordinates |
| sub_rdata | input | 24 | Read data per subordinate, 8 bits each |

## Verification
The assertions assume that reset is released between clock edges and that each subordinate answers exactly one cycle after its read strobe. They make no assumption about whether the read and write strobes can be high together. The stimulus drives a bench model of the subordinates with that one-cycle latency. It changes inputs only on falling edges. It picks addresses with a fixed-seed random generator, inside a chosen window or across the whole 16-bit space, and it sometimes raises both strobes together so that both gating paths are exercised at once.

// File: rtl/csr_dec_pkg.sv
package csr_dec_pkg;
  localparam int MAX_SUB = 32;

  // Local address width of subordinate idx, read from an 8-bit-per-entry list.
  function automatic int sub_width(input logic [MAX_SUB*8-1:0] list, input int idx);
    return int'(list[idx*8 +: 8]);
  endfunction

  // Round x up to a multiple of size (size is a power of two).
  function automatic longint align_up(input longint x, input longint size);
    return ((x + size - 1) / size) * size;
  endfunction

  // Base of window idx: windows in order, each aligned to its own size.
  function automatic longint win_base(input logic [MAX_SUB*8-1:0] list, input int idx);
    longint nxt;
    nxt = 0;
    for (int j = 0; j < idx; j++) begin
      nxt = align_up(nxt, longint'(1) << sub_width(list, j)) + (longint'(1) << sub_width(list, j));
    end
    return align_up(nxt, longint'(1) << sub_width(list, idx));
  endfunction
endpackage

// File: rtl/csr_win_match.sv
module csr_win_match #(
  parameter int     UP_AW  = 16,
  parameter int     SUB_AW = 10,
  parameter longint BASE   = 0
) (
  input  logic [UP_AW-1:0] addr,
  output logic             hit,
  output logic [UP_AW-1:0] local_addr
);
  localparam int     TAG_W = UP_AW - SUB_AW;
  localparam longint TAG   = BASE >> SUB_AW;

  assign hit        = (addr[UP_AW-1:SUB_AW] == TAG_W'(TAG));
  assign local_addr = {{TAG_W{1'b0}}, addr[SUB_AW-1:0]};
endmodule

// File: rtl/csr_rd_steer.sv
module csr_rd_steer #(
  parameter int NUM_SUB = 3,
  parameter int DATA_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd,
  input  logic [NUM_SUB-1:0]        hit,
  input  logic [NUM_SUB*DATA_W-1:0] rdata_in,
  output logic [DATA_W-1:0]         rdata_out
);
  logic [NUM_SUB-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= rd ? hit : '0;
  end

  always_comb begin
    rdata_out = '0;
    for (int i = 0; i < NUM_SUB; i++) begin
      rdata_out = rdata_out | (rdata_in[i*DATA_W +: DATA_W] & {DATA_W{sel_q[i]}});
    end
  end

  // R9: with no read pending, returned data is zero
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == '0) |-> (rdata_out == '0));
  // R8: a read that hits no window returns zero next cycle
  p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && hit == '0) |=> (rdata_out == '0));
endmodule

// File: rtl/csr_win_decoder.sv
module csr_win_decoder #(
  parameter int                                   ADDR_W      = 16,
  parameter int                                   DATA_W      = 8,
  parameter int                                   NUM_SUB     = 3,
  parameter logic [csr_dec_pkg::MAX_SUB*8-1:0]    SUB_AW_LIST = {8'd8, 8'd10, 8'd10}
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         up_addr,
  input  logic                      up_rd,
  input  logic                      up_wr,
  input  logic [DATA_W-1:0]         up_wdata,
  output logic [DATA_W-1:0]         up_rdata,
  output logic [NUM_SUB*ADDR_W-1:0] sub_addr,
  output logic [NUM_SUB-1:0]        sub_rd,
  output logic [NUM_SUB-1:0]        sub_wr,
  output logic [DATA_W-1:0]         sub_wdata,
  input  logic [NUM_SUB*DATA_W-1:0] sub_rdata
);
  logic [NUM_SUB-1:0] win_hit;

  for (genvar i = 0; i < NUM_SUB; i++) begin : g_win
    localparam int     AW_I   = csr_dec_pkg::sub_width(SUB_AW_LIST, i);
    localparam longint BASE_I = csr_dec_pkg::win_base(SUB_AW_LIST, i);
    csr_win_match #(.UP_AW(ADDR_W), .SUB_AW(AW_I), .BASE(BASE_I)) u_match (
      .addr       (up_addr),
      .hit        (win_hit[i]),
      .local_addr (sub_addr[i*ADDR_W +: ADDR_W])
    );
  end

  assign sub_rd    = win_hit & {NUM_SUB{up_rd}};
  assign sub_wr    = win_hit & {NUM_SUB{up_wr}};
  assign sub_wdata = up_wdata;

  csr_rd_steer #(.NUM_SUB(NUM_SUB), .DATA_W(DATA_W)) u_steer (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd        (up_rd),
    .hit       (win_hit),
    .rdata_in  (sub_rdata),
    .rdata_out (up_rdata)
  );

  // R5: windows never overlap
  p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sub_rd) && $onehot0(sub_wr));
  // R4: no subordinate read strobe without an upstream read
  p_rd_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_rd != '0) |-> up_rd);
  // R3: no subordinate write strobe without an upstream write
  p_wr_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_wr != '0) |-> up_wr);
endmodule

// File: tb/sim_csr_win_decoder.sv
module sim_csr_win_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] up_addr = '0;
  logic        up_rd = 1'b0, up_wr = 1'b0;
  logic [7:0]  up_wdata = '0;
  logic [7:0]  up_rdata;
  logic [47:0] sub_addr;
  logic [2:0]  sub_rd, sub_wr;
  logic [7:0]  sub_wdata;
  logic [23:0] sub_rdata = '0;

  int checks = 0, failures = 0;
  bit done = 0;
  int exp_rd = 0;

  always #5 clk = ~clk;

  csr_win_decoder u0 (.*);

  function automatic int win_of(input logic [15:0] a);
    if (a < 16'h0400) return 0;
    if (a < 16'h0800) return 1;
    if (a < 16'h0900) return 2;
    return -1;
  endfunction

  function automatic logic [15:0] local_of(input logic [15:0] a);
    return (win_of(a) == 2) ? (a & 16'h00FF) : (a & 16'h03FF);
  endfunction

  function automatic logic [7:0] model(input int i, input logic [15:0] la);
    return 8'(la * 7 + i * 61 + 3);
  endfunction

  // Bench subordinates: one-cycle read latency
  always_ff @(posedge clk) begin
    for (int i = 0; i < 3; i++)
      if (sub_rd[i]) sub_rdata[i*8 +: 8] <= model(i, sub_addr[i*16 +: 16]);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit rd, input bit wr, input logic [15:0] a, input logic [7:0] wd);
    int w;
    @(negedge clk);
    chk("R6/R7/R9 rdata", int'(up_rdata), exp_rd);
    up_addr = a; up_rd = rd; up_wr = wr; up_wdata = wd;
    #1;
    w = win_of(a);
    chk("R4 sub_rd", int'(sub_rd), (rd && w >= 0) ? (1 << w) : 0);
    chk("R3 sub_wr", int'(sub_wr), (wr && w >= 0) ? (1 << w) : 0);
    if (wr) chk("R3 wdata", int'(sub_wdata), int'(wd));
    if (w >= 0 && (rd || wr)) chk("R2 local addr", int'(sub_addr[w*16 +: 16]), int'(local_of(a)));
    if (w < 0 && (rd || wr)) chk("R8 no strobe", int'({sub_rd, sub_wr}), 0);
    exp_rd = (rd && w >= 0) ? int'(model(w, local_of(a))) : 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R9 reset rdata", int'(up_rdata), 0);
    rst_n = 1'b1;
    // R1 boundaries and R7 back-to-back reads across windows
    step(1, 0, 16'h0000, 0);
    step(1, 0, 16'h0402, 0);
    step(1, 0, 16'h03FF, 0);
    step(1, 0, 16'h0400, 0);
    step(1, 0, 16'h08FF, 0);
    step(1, 0, 16'h0900, 0);   // R8 miss
    step(1, 0, 16'hFFFF, 0);   // R8 miss
    step(0, 0, 16'h0002, 0);   // R9 idle
    step(0, 1, 16'h0402, 8'hAA);
    step(0, 1, 16'h0800, 8'h3D);
    step(0, 1, 16'h0A00, 8'h55);
    for (int k = 0; k < 400; k++) begin
      logic [15:0] a;
      int r = $urandom_range(0, 9);
      if (r < 2) a = 16'($urandom);
      else if (r < 5) a = 16'h0000 + 16'($urandom_range(0, 16'h3FF));
      else if (r < 8) a = 16'h0400 + 16'($urandom_range(0, 16'h3FF));
      else a = 16'h0800 + 16'($urandom_range(0, 16'hFF));
      step(1'($urandom), 1'($urandom), a, 8'($urandom));
    end
    step(0, 0, 16'h0000, 0);
    step(0, 0, 16'h0000, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule